// File: doc/BRIEF.md
# Burst Column Sequencer

This block produces the column addresses of a double-data-rate burst inside one 1024-byte row. Every accepted step moves the burst forward by one byte pair, so the block emits the even column of each pair; the odd byte of the pair is that column plus one. The row address is held elsewhere and never changes during a burst.

A start strobe loads the first column and captures the burst settings: a two-bit length code, a burst-type bit selecting plain or hybrid wrapping, and a linear-command flag. Plain wrapping cycles forever inside the aligned block of the selected length. Hybrid wrapping makes one full wrapped pass through that block, then moves to the next aligned block and walks linearly to the end of the row, after which it keeps cycling through the whole row. The linear command ignores both length and burst type and simply runs through the row, returning to column 0 after column 1022. A stop input, standing for chip select going high, ends the burst.

The column stream leaves on a valid/ready pair. `col_valid` is high for the whole burst. A pair is consumed on every clock edge where `col_valid` and `col_ready` are both high. While `col_ready` is low the current pair is held unchanged and no step is lost, so back-pressure can last any number of cycles.

Top module: `burst_col_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, `col_valid` is 0 and `col_pair` is 0 until the first start strobe.
- R2: A start strobe makes `col_valid` 1 at the next edge with `col_pair` equal to `start_col` with bit 0 forced to 0. Start wins over a stop in the same cycle.
- R3: Each edge with `col_valid` and `col_ready` both high moves the burst one pair forward. With `col_ready` low, `col_pair` holds its value.
- R4: The length code selects the burst block: 0 gives 128 bytes, 1 gives 64, 2 gives 32, 3 gives 16.
- R5: In plain wrap mode (burst type 0, linear flag 0) the column never leaves the aligned block: from column 4 with 32 bytes the pairs run 4, 6, ..., 30, 0, 2, ... indefinitely.
- R6: In hybrid mode (burst type 1, linear flag 0) after length/2 steps of wrapping the next pair is the base of the following aligned block. The burst then runs linearly to 1022 and continues from 0 across the whole row.
- R7: In hybrid mode when the wrap block is the last one in the row, the jump after the wrapped pass lands on column 0.
- R8: With the linear flag set, length code and burst type have no effect. Each step adds 2 modulo 1024.
- R9: A stop makes `col_valid` 0 at the next edge. It stays 0 whatever `col_ready` does until the next start.
- R10: Changing the length code, burst type or linear flag during a burst has no effect until the next start.
- R11: A start strobe during a running burst reloads the column and restarts the hybrid pass count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Loads start column and burst settings |
| stop | input | 1 | Ends the running burst |
| start_col | input | 10 | First column of the burst (bit 0 ignored) |
| len_code | input | 2 | Burst block length code |
| hybrid | input | 1 | 1 selects hybrid wrapping, 0 plain wrapping |
| linear | input | 1 | 1 selects row-linear burst |
| col_valid | output | 1 | A burst is running and `col_pair` is meaningful |
| col_ready | input | 1 | Consumer accepts the current pair |
| col_pair | output | 10 | Even column of the current byte pair |

## Verification
The hardest situation to reach is the end of a hybrid burst's wrapped pass. That is the single step where the column leaves the wrap block, and it occurs only after exactly length/2 accepted steps. The stimulus keeps `col_ready` high through long sweeps from start columns in the middle of a block, including one in the last block of the row, so the jump and the later wrap to 0 both happen. A restart in the middle of a pass, followed by a sweep that crosses a full new pass, shows that the pass count was cleared.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    BM_WRAP   = 2'd0,
    BM_HYBRID = 2'd1,
    BM_LINEAR = 2'd2
  } bmode_e;

endpackage

// File: rtl/bseq_cfg_latch.sv
module bseq_cfg_latch
  import bseq_pkg::*;
#(
  parameter int COL_W        = 10,
  parameter int MAX_LEN_LOG2 = 7,
  parameter int CODE_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] len_code,
  input  logic              hybrid,
  input  logic              linear,
  output bmode_e            mode,
  output logic [COL_W-1:0]  blk_mask
);

  localparam int LG_W = $clog2(MAX_LEN_LOG2 + 1);
  localparam logic [COL_W-1:0] RST_MASK = COL_W'((1 << (MAX_LEN_LOG2 - 2)) - 1);

  logic [LG_W-1:0]  len_lg;
  logic [COL_W-1:0] mask_d;
  bmode_e           mode_d;

  // log2 of the block length: the largest code gives the shortest block
  assign len_lg = LG_W'(MAX_LEN_LOG2) - LG_W'(len_code);

  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask_d[i] = (i < int'(len_lg));
  end

  always_comb begin
    if (linear)      mode_d = BM_LINEAR;
    else if (hybrid) mode_d = BM_HYBRID;
    else             mode_d = BM_WRAP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= BM_WRAP;
      blk_mask <= RST_MASK;
    end else if (load) begin
      mode     <= mode_d;
      blk_mask <= mask_d;
    end
  end

endmodule

// File: rtl/bseq_pass_ctr.sv
module bseq_pass_ctr #(
  parameter int PASS_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [PASS_W-1:0] term,
  output logic              in_pass,
  output logic              pass_last
);

  logic [PASS_W-1:0] cnt;

  assign pass_last = in_pass && (cnt == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      in_pass <= 1'b0;
    end else if (load) begin
      cnt     <= '0;
      in_pass <= 1'b1;
    end else if (step && in_pass) begin
      if (cnt == term) in_pass <= 1'b0;
      else             cnt     <= cnt + PASS_W'(1);
    end
  end

endmodule

// File: rtl/bseq_next_col.sv
module bseq_next_col
  import bseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] cur,
  input  bmode_e           mode,
  input  logic [COL_W-1:0] blk_mask,
  input  logic             in_pass,
  input  logic             pass_last,
  output logic [COL_W-1:0] nxt
);

  logic [COL_W-1:0] inc;
  logic [COL_W-1:0] wrap_nxt;
  logic [COL_W-1:0] jump_nxt;

  assign inc      = cur + COL_W'(2);
  assign wrap_nxt = (cur & ~blk_mask) | (inc & blk_mask);
  // base of the following aligned block; truncation wraps the row
  assign jump_nxt = (cur & ~blk_mask) + blk_mask + COL_W'(1);

  always_comb begin
    unique case (mode)
      BM_WRAP:   nxt = wrap_nxt;
      BM_HYBRID: begin
        if (pass_last)    nxt = jump_nxt;
        else if (in_pass) nxt = wrap_nxt;
        else              nxt = inc;
      end
      default:   nxt = inc;
    endcase
  end

endmodule

// File: rtl/burst_col_sequencer.sv
module burst_col_sequencer
  import bseq_pkg::*;
#(
  parameter int COL_W        = 10,
  parameter int MAX_LEN_LOG2 = 7,
  parameter int CODE_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [COL_W-1:0]  start_col,
  input  logic [CODE_W-1:0] len_code,
  input  logic              hybrid,
  input  logic              linear,
  output logic              col_valid,
  input  logic              col_ready,
  output logic [COL_W-1:0]  col_pair
);

  localparam int PASS_W = MAX_LEN_LOG2 - 1;

  bmode_e           cfg_mode;
  logic [COL_W-1:0] blk_mask;
  logic [COL_W-1:0] nxt_col;
  logic             in_pass;
  logic             pass_last;
  logic             fire;

  assign fire = col_valid && col_ready && !start && !stop;

  bseq_cfg_latch #(
    .COL_W(COL_W), .MAX_LEN_LOG2(MAX_LEN_LOG2), .CODE_W(CODE_W)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n), .load(start),
    .len_code(len_code), .hybrid(hybrid), .linear(linear),
    .mode(cfg_mode), .blk_mask(blk_mask)
  );

  bseq_pass_ctr #(.PASS_W(PASS_W)) i_pass (
    .clk(clk), .rst_n(rst_n), .load(start), .step(fire),
    .term(blk_mask[PASS_W:1]),
    .in_pass(in_pass), .pass_last(pass_last)
  );

  bseq_next_col #(.COL_W(COL_W)) i_next (
    .cur(col_pair), .mode(cfg_mode), .blk_mask(blk_mask),
    .in_pass(in_pass), .pass_last(pass_last), .nxt(nxt_col)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_valid <= 1'b0;
      col_pair  <= '0;
    end else if (start) begin
      col_valid <= 1'b1;
      col_pair  <= {start_col[COL_W-1:1], 1'b0};
    end else if (stop) begin
      col_valid <= 1'b0;
    end else if (fire) begin
      col_pair  <= nxt_col;
    end
  end

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker
  import bseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic [COL_W-1:0] start_col,
  input logic             col_valid,
  input logic             col_ready,
  input logic [COL_W-1:0] col_pair,
  input bmode_e           mode,
  input logic [COL_W-1:0] blk_mask
);

  logic step_ok;
  assign step_ok = col_valid && col_ready && !start && !stop;

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && (col_pair == {$past(start_col[COL_W-1:1]), 1'b0})); // R2

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready && !start && !stop) |=> $stable(col_pair)); // R3

  AST_WRAP_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && mode == BM_WRAP)
      |=> ((col_pair & ~blk_mask) == $past(col_pair & ~blk_mask))); // R5

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && mode == BM_LINEAR)
      |=> (col_pair == COL_W'($past(col_pair) + COL_W'(2)))); // R8

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !col_valid); // R9

  AST_EVEN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> (col_pair[0] == 1'b0)); // R2

endmodule

bind burst_col_sequencer bseq_checker #(.COL_W(COL_W)) i_bseq_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
  .start_col(start_col), .col_valid(col_valid), .col_ready(col_ready),
  .col_pair(col_pair), .mode(cfg_mode), .blk_mask(blk_mask)
);

// File: tb/test_burst_col_sequencer.sv
module test_burst_col_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       stop = 1'b0;
  logic [9:0] start_col = '0;
  logic [1:0] len_code = '0;
  logic       hybrid = 1'b0;
  logic       linear = 1'b0;
  logic       col_valid;
  logic       col_ready = 1'b0;
  logic [9:0] col_pair;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_col_sequencer i_burst_col_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .start_col(start_col), .len_code(len_code), .hybrid(hybrid),
    .linear(linear), .col_valid(col_valid), .col_ready(col_ready),
    .col_pair(col_pair)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // md: 0 plain wrap, 1 hybrid, 2 linear; k-th pair of the burst
  function automatic int exp_col(int md, int s, int bl, int k);
    int base = s & ~(bl - 1);
    int off  = s % bl;
    if (md == 2) return (s + 2 * k) % 1024;
    if (md == 0 || k < bl / 2) return base + ((off + 2 * k) % bl);
    return (base + bl + 2 * (k - bl / 2)) % 1024;
  endfunction

  task automatic kick(input int s, input int code, input bit hyb, input bit lin);
    start = 1'b1; start_col = 10'(s); len_code = 2'(code);
    hybrid = hyb; linear = lin;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic sweep(input int md, input int s, input int bl, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      check(req, int'(col_valid), 1);
      check(req, int'(col_pair), exp_col(md, s, bl, k));
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check("R1", int'(col_valid), 0);
    check("R1", int'(col_pair), 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", int'(col_valid), 0);
    check("R1", int'(col_pair), 0);
  endtask

  task automatic t_plain_wrap;
    col_ready = 1'b1;
    kick(4, 2, 0, 0);   sweep(0, 4, 32, 40, "R5");
    kick(126, 0, 0, 0); sweep(0, 126, 128, 70, "R4");
    kick(60, 1, 0, 0);  sweep(0, 60, 64, 40, "R4");
    kick(14, 3, 0, 0);  sweep(0, 14, 16, 24, "R4");
  endtask

  task automatic t_hybrid;
    col_ready = 1'b1;
    kick(2, 2, 1, 0);   sweep(1, 2, 32, 16 + 496 + 6, "R6");
    kick(996, 2, 1, 0); sweep(1, 996, 32, 30, "R7");
  endtask

  task automatic t_linear;
    col_ready = 1'b1;
    kick(1000, 3, 1, 1); sweep(2, 1000, 16, 24, "R8");
  endtask

  task automatic t_stall;
    col_ready = 1'b1;
    kick(10, 3, 0, 0);
    check("R3", int'(col_pair), 10);
    @(negedge clk);
    check("R3", int'(col_pair), 12);
    col_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R3", int'(col_pair), 12);
    end
    col_ready = 1'b1;
    @(negedge clk);
    check("R3", int'(col_pair), 14);
    @(negedge clk);
    check("R5", int'(col_pair), 0);
  endtask

  task automatic t_stop;
    col_ready = 1'b1;
    kick(100, 2, 0, 0);
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check("R9", int'(col_valid), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9", int'(col_valid), 0);
    end
    stop = 1'b1;
    kick(20, 2, 0, 0);
    stop = 1'b0;
    check("R2", int'(col_valid), 1);
    check("R2", int'(col_pair), 20);
    kick(35, 2, 0, 0);
    check("R2", int'(col_pair), 34);
  endtask

  task automatic t_cfg_hold;
    col_ready = 1'b1;
    kick(6, 3, 0, 0);
    len_code = 2'd0; hybrid = 1'b1; linear = 1'b1;
    sweep(0, 6, 16, 12, "R10");
  endtask

  task automatic t_restart;
    col_ready = 1'b1;
    kick(2, 2, 1, 0);
    sweep(1, 2, 32, 5, "R11");
    kick(40, 1, 1, 0);
    sweep(1, 40, 64, 40, "R11");
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_plain_wrap();
    t_hybrid();
    t_linear();
    t_stall();
    t_stop();
    t_cfg_hold();
    t_restart();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule